// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three digital supply comparator flags into the staged response a microcontroller core needs while its supply collapses and returns. The flags report the supply below an early-warning level, below the minimum operating level, and below the level at which the backup cell takes over. The analogue reference and comparators sit outside the block; only their flag outputs arrive here.

A first fall below the warning level raises a one-cycle interrupt request toward a fixed vector, and only if software has enabled the warning. The core keeps running. A fall below the minimum level holds the core in reset. For as long as that reset lasts, it also forces the external memory chip enables and the read/write strobe to their idle high level. A fall below the backup level selects the backup cell as the power source. When the supply recovers past the minimum level, reset is still held for a fixed power-on delay before code may run again.

Each flag passes through a synchroniser before use. All timing below counts clock edges of `clk`.

Top module: `pwr_fail_seq`

## Requirements
- R1: When the synchronised warning flag first goes high and `warn_en` is high at that edge, `irq_req` is high for exactly one cycle. `irq_vector` always reads 8'h2B.
- R2: While only the warning flag is high, `cpu_reset` and `strobe_off` stay low, so the core keeps running.
- R3: A high `below_min` sampled at edge k drives `cpu_reset` high after edge k+1.
- R4: `strobe_off` is high in exactly the cycles in which `cpu_reset` is high.
- R5: `cpu_reset` stays high for as long as the synchronised minimum flag stays high.
- R6: `use_backup` follows `below_backup` with the same two-edge latency. A value of 1 selects the backup cell.
- R7: After the synchronised minimum flag clears, `cpu_reset` stays high for POR_CYCLES further cycles (default 21504). The same hold follows the release of `rst_n`.
- R8: The warning interrupt fires at most once per excursion below the warning level. It re-arms only after the synchronised warning flag has been low for a cycle. An excursion whose edge falls while `warn_en` is low gives no request.
- R9: While `rst_n` is low, `irq_req` = 0, `cpu_reset` = 1, `strobe_off` = 1 and `use_backup` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_en | input | 1 | Enables the early-warning interrupt |
| below_warn | input | 1 | Comparator: supply below warning level (asynchronous) |
| below_min | input | 1 | Comparator: supply below minimum operating level (asynchronous) |
| below_backup | input | 1 | Comparator: supply below backup switch level (asynchronous) |
| irq_req | output | 1 | One-cycle power-fail interrupt request |
| irq_vector | output | 8 | Interrupt vector, constant 8'h2B |
| cpu_reset | output | 1 | Processor reset, active high |
| strobe_off | output | 1 | Forces chip enables and read/write to logic 1 |
| use_backup | output | 1 | Power source select, 1 = backup cell |

## Verification
A wrong arming bit shows up on `irq_req` within three edges of the warning flag rising, either as a missing pulse or as a second pulse on the same excursion. A wrong power-on counter is seen only at the end of the hold, about 21504 cycles after the minimum flag clears, when reset falls one or more cycles early or late. The bench compares every output on every cycle against its model, so an off-by-one in that count or in the synchroniser depth is reported on the cycle it occurs.

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
  parameter int          POR_CYCLES  = 21504,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  IRQ_VECTOR  = 8'h2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warn_en,
  input  logic       below_warn,
  input  logic       below_min,
  input  logic       below_backup,
  output logic       irq_req,
  output logic [7:0] irq_vector,
  output logic       cpu_reset,
  output logic       strobe_off,
  output logic       use_backup
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYCLES);

  logic [SYNC_STAGES-1:0] sw, sm, sb;
  logic w_s, m_s, b_s, armed;
  logic [CW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw <= '0;
      sm <= '0;
      sb <= '0;
    end else begin
      sw <= {sw[SYNC_STAGES-2:0], below_warn};
      sm <= {sm[SYNC_STAGES-2:0], below_min};
      sb <= {sb[SYNC_STAGES-2:0], below_backup};
    end

  assign w_s = sw[SYNC_STAGES-1];
  assign m_s = sm[SYNC_STAGES-1];
  assign b_s = sb[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed   <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      armed   <= !w_s;
      irq_req <= w_s && armed && warn_en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           hold <= POR_LOAD;
    else if (m_s)         hold <= POR_LOAD;
    else if (hold != '0)  hold <= hold - 1'b1;

  assign cpu_reset  = m_s || (hold != '0);
  assign strobe_off = cpu_reset;
  assign use_backup = b_s;
  assign irq_vector = IRQ_VECTOR;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;

  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(warn_en));
  a_r8_irq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  a_r3_reset_follows_min: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(below_min, 2)) |-> cpu_reset);
  a_r6_backup_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    use_backup |-> cpu_reset);
  a_r7_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> !m_s && $past(hold) == CW'(1));
endmodule

// File: tb/pwr_fail_seq_bench.sv
module pwr_fail_seq_bench;
  localparam int POR = 21504;
  logic clk = 1'b0, rst_n = 1'b0;
  logic warn_en = 1'b0, below_warn = 1'b0, below_min = 1'b0, below_backup = 1'b0;
  logic irq_req, cpu_reset, strobe_off, use_backup;
  logic [7:0] irq_vector;
  int checks = 0, errors = 0, cycles = 0, irq_seen = 0;
  bit done = 1'b0;

  pwr_fail_seq u_pwr_fail_seq (.*);

  always #10 clk = ~clk;

  int w[$], m[$], b[$];
  int e_irq = 0, e_arm = 0, e_cnt = POR;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w = '{0, 0}; m = '{0, 0}; b = '{0, 0};
      e_irq = 0; e_arm = 0; e_cnt = POR;
    end else begin
      e_irq = (w[1] && e_arm && warn_en) ? 1 : 0;
      e_arm = w[1] ? 0 : 1;
      if (m[1]) e_cnt = POR;
      else if (e_cnt > 0) e_cnt = e_cnt - 1;
      w.push_front(int'(below_warn)); void'(w.pop_back());
      m.push_front(int'(below_min));  void'(m.pop_back());
      b.push_front(int'(below_backup)); void'(b.pop_back());
    end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int er;
    cycles++;
    er = (m[1] || e_cnt > 0) ? 1 : 0;
    if (!rst_n) er = 1;
    chk("R1/R8 irq_req", int'(irq_req), e_irq);
    chk("R1 irq_vector", int'(irq_vector), 8'h2B);
    chk("R2/R3/R5/R7 cpu_reset", int'(cpu_reset), er);
    chk("R4 strobe_off", int'(strobe_off), er);
    chk("R6 use_backup", int'(use_backup), b[1]);
    if (irq_req) irq_seen++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    w = '{0, 0}; m = '{0, 0}; b = '{0, 0};
    wait_n(3);
    chk("R9 reset irq", int'(irq_req), 0);
    chk("R9 reset cpu_reset", int'(cpu_reset), 1);
    chk("R9 reset backup", int'(use_backup), 0);
    rst_n = 1'b1;
    wait_n(POR + 5);
    chk("R7 released after power-on hold", int'(cpu_reset), 0);
    warn_en = 1'b1; below_warn = 1'b1;
    wait_n(20);
    chk("R1 one irq on first warning", irq_seen, 1);
    chk("R2 running while only warning", int'(cpu_reset), 0);
    below_warn = 1'b0; wait_n(5);
    warn_en = 1'b0; below_warn = 1'b1; wait_n(10);
    warn_en = 1'b1; wait_n(10);
    chk("R8 no irq for disabled excursion", irq_seen, 1);
    below_warn = 1'b0; wait_n(1); below_warn = 1'b1; wait_n(10);
    chk("R8 re-armed after one low cycle", irq_seen, 2);
    below_min = 1'b1; wait_n(10);
    below_backup = 1'b1; wait_n(10);
    chk("R6 backup selected", int'(use_backup), 1);
    below_backup = 1'b0; wait_n(10);
    below_min = 1'b1; wait_n(50);
    chk("R5 reset held while below minimum", int'(cpu_reset), 1);
    below_min = 1'b0; wait_n(POR - 10);
    chk("R7 still held before count ends", int'(cpu_reset), 1);
    wait_n(30);
    chk("R7 released after count", int'(cpu_reset), 0);
    below_warn = 1'b0; wait_n(10);
    below_min = 1'b1; wait_n(1); below_min = 1'b0; wait_n(POR + 10);
    chk("R3 short dip still caught", int'(cpu_reset), 0);
    chk("R8 total irq count", irq_seen, 2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule